// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides which received CAN frames are kept. A bank of eight programmable code bytes and eight mask bytes can be grouped as two 32-bit filters, four 16-bit filters or eight 8-bit filters. A fourth setting shuts the bank so that nothing passes. Each offered identifier, together with its IDE and RTR bits, is checked against every active filter. The block reports whether the frame is kept and which filter matched. When several filters match, the lowest-numbered one wins.

The index of the matching filter does not go straight to software. It is queued with the frame in a small tag queue that tracks the receive message queue. It reaches the visible hit indicator only when the host advances the receive queue and that frame becomes the head. Configuration goes through a small byte-wide register port. Writes take effect only while the host holds both its initialization request and the acknowledge. Reads are allowed at any time.

Identifiers enter on a valid/ready stream. A frame is taken on a cycle where `id_valid` and `id_ready` are both high. `id_ready` drops while the tag queue holds `DEPTH` entries, because a further kept frame could not be stored. While `id_ready` is low, the source must hold the frame. The decision outputs are single-cycle status and cannot stall.

Top module: `can_accept_filter`

## Requirements
- R1: After reset the mode field is 00, the hit indicator reads 000, no frame decision is flagged, all code and mask bytes read 0, and `id_ready` is high.
- R2: Register map: address 0 is control, with the mode in bits [5:4], the hit indicator in bits [2:0] and the other bits reading 0. Addresses 8+k hold code byte k and addresses 16+k hold mask byte k, for k = 0..7. Every other address reads 0. A write changes a register only when `init_req` and `init_ack` are both high; otherwise the register keeps its value. `reg_rdata` always shows the addressed register.
- R3: A write to address 0 never changes the hit indicator bits [2:0].
- R4: Mode 00 gives two filters over the key {identifier[28:0], IDE, RTR, 0}, with bit 31 first. Filter f uses code and mask bytes 4f..4f+3, and byte 4f is the most significant. Key bit 0 is never compared.
- R5: Mode 01 gives four filters. Filter f compares identifier bits [28:13] with bytes 2f (high) and 2f+1 (low).
- R6: Mode 10 gives eight filters. Filter f compares identifier bits [28:21] with byte f.
- R7: Mode 11 accepts no frame and queues no hit index, whatever the code and mask bytes hold.
- R8: A mask bit of 1 makes the matching key bit a don't-care. A filter matches when every other compared bit equals its code bit.
- R9: When several filters match, the lowest-numbered one is reported.
- R10: The cycle after a frame is taken, `frame_valid` is high for one cycle, and `frame_accept` and `frame_hit` give the decision. `frame_hit` reads 0 for a rejected frame.
- R11: The index of each kept frame joins a tag queue. A `queue_adv` pulse while the queue is not empty loads the oldest index into the hit indicator on the next edge. A pulse while the queue is empty, and any new match, leaves the indicator unchanged.
- R12: `id_ready` is low exactly while `DEPTH` indices are queued. A frame offered during that time is not taken and produces no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_req | input | 1 | Host initialization request |
| init_ack | input | 1 | Initialization acknowledge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Readback of the addressed register |
| id_valid | input | 1 | Identifier offered |
| id_ready | output | 1 | Identifier can be taken |
| id_ext | input | 29 | Received identifier, bit 28 first on the bus |
| id_ide | input | 1 | IDE bit of the frame |
| id_rtr | input | 1 | RTR bit of the frame |
| queue_adv | input | 1 | Receive queue advance strobe |
| frame_valid | output | 1 | Decision present for the last taken frame |
| frame_accept | output | 1 | That frame is kept |
| frame_hit | output | 3 | Index of the matching filter |
| head_hit | output | 3 | Hit indicator of the head-of-queue frame |

## Verification
The bench sets up configurations in which several filters match at once. A priority encoder that scans in the wrong direction would then report the highest index. Some frames differ from a filter's code only in the RTR bit or in a masked byte. These catch a key with the wrong bit order, a mask with inverted polarity, and a 32-bit compare that wrongly includes or drops bit 0. Writes are tried with only the request asserted, and the hit bits are written directly. A design that ignores the acknowledge, or lets software set the hit bits, would show the changed value on readback. The tag queue is filled to capacity and then drained one advance at a time, with one extra advance on the empty queue. This exposes indices that land at match time instead of advance time, that come out in the wrong order, that are lost when the queue is full, or that change when an advance finds nothing queued.

// File: rtl/caf_pkg.sv
package caf_pkg;
  localparam int ID_W   = 29;
  localparam int KEY_W  = 32;
  localparam int NBYTES = 8;
  localparam int TAG_W  = $clog2(NBYTES);

  typedef enum logic [1:0] {
    FM_WIDE = 2'b00,
    FM_HALF = 2'b01,
    FM_BYTE = 2'b10,
    FM_SHUT = 2'b11
  } fmode_e;
endpackage

// File: rtl/caf_regs.sv
module caf_regs
  import caf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_open,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [7:0]                    wr_data,
  input  logic [TAG_W-1:0]              head_tag,
  output fmode_e                        mode,
  output logic [NBYTES-1:0][7:0]        code,
  output logic [NBYTES-1:0][7:0]        mask,
  output logic [7:0]                    rd_data
);
  localparam int SEL_W = $clog2(NBYTES);
  localparam logic [ADDR_W-SEL_W-1:0] GRP_CTRL = 0;
  localparam logic [ADDR_W-SEL_W-1:0] GRP_CODE = 1;
  localparam logic [ADDR_W-SEL_W-1:0] GRP_MASK = 2;

  logic [ADDR_W-SEL_W-1:0] grp;
  logic [SEL_W-1:0]        sel;
  assign grp = addr[ADDR_W-1:SEL_W];
  assign sel = addr[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= FM_WIDE;
      code <= '0;
      mask <= '0;
    end else if (wr_en && cfg_open) begin
      if (grp == GRP_CTRL && sel == '0)
        mode <= fmode_e'(wr_data[5:4]);
      else if (grp == GRP_CODE)
        code[sel] <= wr_data;
      else if (grp == GRP_MASK)
        mask[sel] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (grp == GRP_CTRL && sel == '0)
      rd_data = {2'b00, mode, 1'b0, head_tag};
    else if (grp == GRP_CODE)
      rd_data = code[sel];
    else if (grp == GRP_MASK)
      rd_data = mask[sel];
  end
endmodule

// File: rtl/caf_match.sv
module caf_match
  import caf_pkg::*;
(
  input  fmode_e                   mode,
  input  logic [NBYTES-1:0][7:0]   code,
  input  logic [NBYTES-1:0][7:0]   mask,
  input  logic [ID_W-1:0]          id,
  input  logic                     ide,
  input  logic                     rtr,
  output logic                     hit_any,
  output logic [TAG_W-1:0]         hit_idx
);
  localparam int N16 = NBYTES / 2;
  localparam int N32 = NBYTES / 4;

  logic [KEY_W-1:0]  key;
  logic [NBYTES-1:0] m8;
  logic [N16-1:0]    m16;
  logic [N32-1:0]    m32;
  logic [NBYTES-1:0] hits;

  assign key = {id, ide, rtr, 1'b0};

  for (genvar f = 0; f < NBYTES; f++) begin : g_b8
    assign m8[f] = ((key[KEY_W-1 -: 8] ^ code[f]) & ~mask[f]) == '0;
  end

  for (genvar f = 0; f < N16; f++) begin : g_b16
    logic [15:0] c16, k16;
    assign c16 = {code[2*f], code[2*f+1]};
    assign k16 = {mask[2*f], mask[2*f+1]};
    assign m16[f] = ((key[KEY_W-1 -: 16] ^ c16) & ~k16) == '0;
  end

  for (genvar f = 0; f < N32; f++) begin : g_b32
    logic [31:0] c32, k32;
    assign c32 = {code[4*f], code[4*f+1], code[4*f+2], code[4*f+3]};
    assign k32 = {mask[4*f], mask[4*f+1], mask[4*f+2], mask[4*f+3]} | 32'd1;
    assign m32[f] = ((key ^ c32) & ~k32) == '0;
  end

  always_comb begin
    case (mode)
      FM_WIDE: hits = NBYTES'(m32);
      FM_HALF: hits = NBYTES'(m16);
      FM_BYTE: hits = m8;
      default: hits = '0;
    endcase
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NBYTES - 1; i >= 0; i--)
      if (hits[i]) hit_idx = i[TAG_W-1:0];
  end

  assign hit_any = |hits;
endmodule

// File: rtl/caf_tag_fifo.sv
module caf_tag_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import caf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              id_valid,
  output logic              id_ready,
  input  logic [ID_W-1:0]   id_ext,
  input  logic              id_ide,
  input  logic              id_rtr,
  input  logic              queue_adv,
  output logic              frame_valid,
  output logic              frame_accept,
  output logic [TAG_W-1:0]  frame_hit,
  output logic [TAG_W-1:0]  head_hit
);
  fmode_e                 mode_q;
  logic [NBYTES-1:0][7:0] code_q, mask_q;
  logic                   m_any;
  logic [TAG_W-1:0]       m_idx, q_head;
  logic                   q_full, q_empty, take, pop_ok;

  assign take     = id_valid && id_ready;
  assign id_ready = !q_full;
  assign pop_ok   = queue_adv && !q_empty;

  caf_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_open(init_req && init_ack),
    .wr_en(reg_we), .addr(reg_addr), .wr_data(reg_wdata),
    .head_tag(head_hit), .mode(mode_q), .code(code_q), .mask(mask_q),
    .rd_data(reg_rdata)
  );

  caf_match u_match (
    .mode(mode_q), .code(code_q), .mask(mask_q),
    .id(id_ext), .ide(id_ide), .rtr(id_rtr),
    .hit_any(m_any), .hit_idx(m_idx)
  );

  caf_tag_fifo #(.DEPTH(DEPTH), .W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .push(take && m_any), .pop(pop_ok),
    .din(m_idx), .dout(q_head), .full(q_full), .empty(q_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid  <= 1'b0;
      frame_accept <= 1'b0;
      frame_hit    <= '0;
      head_hit     <= '0;
    end else begin
      frame_valid  <= take;
      frame_accept <= take && m_any;
      frame_hit    <= (take && m_any) ? m_idx : '0;
      if (pop_ok) head_hit <= q_head;
    end
  end
endmodule

// File: rtl/caf_chk.sv
module caf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_req,
  input logic       init_ack,
  input logic       id_valid,
  input logic       id_ready,
  input logic       queue_adv,
  input logic       frame_valid,
  input logic       frame_accept,
  input logic [2:0] frame_hit,
  input logic [2:0] head_hit,
  input logic [1:0] mode_q
);
  // R12
  no_take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !id_ready) |=> !frame_valid);

  // R10
  valid_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(id_valid && id_ready));

  // R10
  reject_hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !frame_accept) |-> (frame_hit == 3'd0));

  // R7
  shut_never_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |-> ($past(mode_q) != 2'b11));

  // R2
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_req && init_ack) |=> $stable(mode_q));

  // R11
  head_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_adv |=> $stable(head_hit));
endmodule

bind can_accept_filter caf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
  .id_valid(id_valid), .id_ready(id_ready), .queue_adv(queue_adv),
  .frame_valid(frame_valid), .frame_accept(frame_accept),
  .frame_hit(frame_hit), .head_hit(head_hit), .mode_q(mode_q)
);

// File: tb/tb_can_accept_filter.sv
`timescale 1ns/100ps
module tb_can_accept_filter;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic init_req = 0, init_ack = 0, reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic id_valid = 0, id_ready, id_ide = 0, id_rtr = 0, queue_adv = 0;
  logic [28:0] id_ext = 0;
  logic frame_valid, frame_accept;
  logic [2:0] frame_hit, head_hit;

  int n_chk = 0, n_bad = 0;
  bit chk_on = 0;

  always #2.5 clk = ~clk;

  can_accept_filter #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .id_valid(id_valid), .id_ready(id_ready),
    .id_ext(id_ext), .id_ide(id_ide), .id_rtr(id_rtr), .queue_adv(queue_adv),
    .frame_valid(frame_valid), .frame_accept(frame_accept),
    .frame_hit(frame_hit), .head_hit(head_hit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] mcode [8];
  logic [7:0] mmask [8];
  int  mmode, mhead, mhit;
  bit  mfv, macc;
  int  q[$];

  function automatic void ref_match(input logic [28:0] id, input logic ide,
                                    input logic rtr, output bit acc, output int hit);
    logic [31:0] key, c, m, k;
    int n, nb;
    key = {id, ide, rtr, 1'b0};
    acc = 0; hit = 0;
    case (mmode)
      0: n = 2;
      1: n = 4;
      2: n = 8;
      default: n = 0;
    endcase
    if (n == 0) return;
    nb = 8 / n;
    for (int f = n - 1; f >= 0; f--) begin
      c = 0; m = 0;
      for (int b = 0; b < nb; b++) begin
        c = (c << 8) | 32'(mcode[f*nb+b]);
        m = (m << 8) | 32'(mmask[f*nb+b]);
      end
      k = key >> (32 - nb*8);
      if (nb == 4) m[0] = 1'b1;
      if (((k ^ c) & ~m) == 0) begin acc = 1; hit = f; end
    end
  endfunction

  function automatic logic [7:0] ref_rd(input logic [4:0] a);
    if (a == 0) return {2'b00, 2'(mmode), 1'b0, 3'(mhead)};
    if (a >= 8 && a < 16) return mcode[a-8];
    if (a >= 16 && a < 24) return mmask[a-16];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin mcode[i] = 0; mmask[i] = 0; end
      mmode = 0; mhead = 0; mfv = 0; macc = 0; mhit = 0; q.delete();
    end else begin
      bit fire, a; int h;
      fire = id_valid && (q.size() < DEPTH);
      ref_match(id_ext, id_ide, id_rtr, a, h);
      if (queue_adv && q.size() > 0) mhead = q.pop_front();
      mfv = fire; macc = fire && a; mhit = (fire && a) ? h : 0;
      if (fire && a) q.push_back(h);
      if (reg_we && init_req && init_ack) begin
        if (reg_addr == 0) mmode = int'(reg_wdata[5:4]);
        else if (reg_addr >= 8 && reg_addr < 16) mcode[reg_addr-8] = reg_wdata;
        else if (reg_addr >= 16 && reg_addr < 24) mmask[reg_addr-16] = reg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (chk_on) begin
      check(reg_rdata == ref_rd(reg_addr), "R2", "rdata", reg_rdata, ref_rd(reg_addr));
      check(id_ready == (q.size() < DEPTH), "R12", "id_ready", id_ready, q.size() < DEPTH);
      check(frame_valid == mfv, "R10", "frame_valid", frame_valid, mfv);
      check(frame_accept == macc, "R10", "frame_accept", frame_accept, macc);
      check(frame_hit == 3'(mhit), "R10", "frame_hit", frame_hit, mhit);
      check(head_hit == 3'(mhead), "R11", "head_hit", head_hit, mhead);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rdchk(input logic [4:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); reg_addr = a; #1;
    check(reg_rdata == exp, req, "readback", reg_rdata, exp);
  endtask

  task automatic send(input logic [28:0] id, input logic ide, input logic rtr,
                      input bit exp_acc, input int exp_hit, input string req);
    @(negedge clk); id_valid = 1; id_ext = id; id_ide = ide; id_rtr = rtr;
    @(negedge clk); id_valid = 0; #1;
    check(frame_valid == 1'b1, req, "taken", frame_valid, 1);
    check(frame_accept == exp_acc, req, "accept", frame_accept, exp_acc);
    check(frame_hit == 3'(exp_hit), req, "hit", frame_hit, exp_hit);
  endtask

  task automatic adv(input int exp_head, input string req);
    @(negedge clk); queue_adv = 1;
    @(negedge clk); queue_adv = 0; #1;
    check(head_hit == 3'(exp_head), req, "head_hit", head_hit, exp_head);
  endtask

  function automatic logic [31:0] keyof(input logic [28:0] id, input logic ide, input logic rtr);
    return {id, ide, rtr, 1'b0};
  endfunction

  localparam logic [28:0] IDA = 29'h0ABCDEF;
  localparam logic [28:0] IDC = 29'h0A5B3C2;
  localparam logic [28:0] IDD = 29'h0A00000; // bits [28:21] = 8'h05

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] k;
    repeat (3) @(negedge clk);
    rst_n = 1; chk_on = 1;
    #1;
    // R1 reset state
    check(reg_rdata == 8'h00, "R1", "ctrl", reg_rdata, 0);
    check(id_ready == 1'b1, "R1", "id_ready", id_ready, 1);
    check(head_hit == 3'd0, "R1", "head_hit", head_hit, 0);
    check(frame_valid == 1'b0, "R1", "frame_valid", frame_valid, 0);
    rdchk(5'd12, 8'h00, "R1");

    init_req = 1; init_ack = 1;
    // R4 two wide filters: filter0 exact A, filter1 open
    k = keyof(IDA, 1'b1, 1'b0);
    for (int b = 0; b < 4; b++) begin
      wr(5'(8 + b), k[31-8*b -: 8]); wr(5'(16 + b), 8'h00);
      wr(5'(12 + b), 8'h00);         wr(5'(20 + b), 8'hFF);
    end
    rdchk(5'd8, k[31:24], "R2");
    send(IDA, 1'b1, 1'b0, 1, 0, "R9");   // both match, lowest wins
    adv(0, "R11");
    send(29'h1555555, 1'b0, 1'b0, 1, 1, "R8");
    adv(1, "R11");
    for (int b = 0; b < 4; b++) wr(5'(20 + b), 8'h00);
    send(IDA, 1'b1, 1'b1, 0, 0, "R4");   // RTR differs: rejected
    send(29'h0, 1'b0, 1'b0, 1, 1, "R4"); // key all zero hits filter1
    adv(1, "R11");
    wr(5'd19, 8'hFF);                    // don't-care on lowest key byte
    send(IDA ^ 29'h1, 1'b1, 1'b1, 1, 0, "R8");
    adv(0, "R11");

    // R5 four 16-bit filters
    wr(5'd0, 8'h10);
    for (int b = 0; b < 8; b++) begin wr(5'(8 + b), 8'hFF); wr(5'(16 + b), 8'h00); end
    k = keyof(IDC, 1'b0, 1'b0);
    wr(5'd12, k[31:24]); wr(5'd13, k[23:16]);
    send(IDC, 1'b0, 1'b0, 1, 2, "R5");
    adv(2, "R11");
    send(IDC ^ 29'h1FFF, 1'b1, 1'b1, 1, 2, "R5");
    adv(2, "R11");

    // R6 eight byte filters
    wr(5'd0, 8'h20);
    for (int b = 0; b < 8; b++) wr(5'(8 + b), 8'h00);
    wr(5'd13, 8'h05);
    send(IDD, 1'b0, 1'b0, 1, 5, "R6");
    adv(5, "R11");
    wr(5'd11, 8'h05);
    send(IDD, 1'b0, 1'b0, 1, 3, "R9");
    adv(3, "R11");

    // R2 writes ignored without acknowledge
    init_ack = 0;
    wr(5'd0, 8'h30);
    wr(5'd8, 8'hAA);
    rdchk(5'd0, 8'h23, "R2");
    rdchk(5'd8, 8'h00, "R2");
    init_ack = 1;
    // R3 hit bits read-only
    wr(5'd0, 8'h27);
    rdchk(5'd0, 8'h23, "R3");

    // R7 shut mode with everything masked
    for (int b = 0; b < 8; b++) wr(5'(16 + b), 8'hFF);
    wr(5'd0, 8'h30);
    send(IDA, 1'b0, 1'b0, 0, 0, "R7");
    send(29'h0, 1'b1, 1'b1, 0, 0, "R7");

    // R11/R12 fill the tag queue
    wr(5'd0, 8'h20);
    for (int b = 0; b < 8; b++) begin wr(5'(8 + b), 8'(b)); wr(5'(16 + b), 8'h00); end
    send(29'(1) << 21, 1'b0, 1'b0, 1, 1, "R11");
    check(head_hit == 3'd3, "R11", "head before adv", head_hit, 3);
    send(29'(6) << 21, 1'b0, 1'b0, 1, 6, "R11");
    send(29'(2) << 21, 1'b0, 1'b0, 1, 2, "R11");
    send(29'(4) << 21, 1'b0, 1'b0, 1, 4, "R12");
    check(id_ready == 1'b0, "R12", "ready when full", id_ready, 0);
    @(negedge clk); id_valid = 1; id_ext = 29'(5) << 21;
    repeat (3) begin
      @(negedge clk); #1;
      check(frame_valid == 1'b0, "R12", "no take when full", frame_valid, 0);
    end
    id_valid = 0;
    adv(1, "R11");
    adv(6, "R11");
    adv(2, "R11");
    adv(4, "R11");
    adv(4, "R11");                       // empty queue: unchanged
    check(id_ready == 1'b1, "R12", "ready after drain", id_ready, 1);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule